// File: doc/BRIEF.md
# Programmable Down-Counter/Timer Channel

This block is a single counter/timer channel programmed over a byte-wide write port. A control byte sets the operating mode, the prescaler, the trigger polarity, the start condition and the interrupt enable. When its "time constant follows" bit is set, the byte written next is taken as the reload value of an internal down-counter.

In timer mode the down-counter steps once per prescaler period of 16 or 256 system clocks. In counter mode it steps once per qualifying edge of an external trigger. The trigger is brought into the clock domain by a two-flop synchronizer and then passed to an edge detector.

Each time the count reaches zero, the counter reloads itself and the channel emits a one-clock pulse. If interrupts are enabled, it also sets a sticky request flag, which stays set until the host clears it.

Top module: `ctr_timer_chan`

Control byte bit positions:

| Bit | Meaning |
|-----|---------|
| 7 | Interrupt enable |
| 6 | Counter mode (1) or timer mode (0) |
| 5 | Prescaler of 256 (1) or 16 (0) |
| 4 | Rising trigger edge (1) or falling trigger edge (0) |
| 3 | Timer waits for a trigger edge before it starts |
| 2 | The next write is a time constant |
| 1 | Soft reset |
| 0 | Ignored |

## Requirements
- R1: A write is a time constant only when the control byte before it had bit 2 set. Any other write is a control byte, even when that byte has bit 1 set. A control byte with neither bit 1 nor bit 2 set updates the configuration and does not stop counting.
- R2: A time-constant byte N from 1 to 255 loads N into the counter. The byte 0x00 loads 256.
- R3: In timer mode (bit 6 = 0) with automatic start (bit 3 = 0), the first zero-count pulse is seen P*N cycles after the clock edge that takes the time-constant write. P is 16 when bit 5 = 0 and 256 when bit 5 = 1.
- R4: At zero count the counter reloads N and keeps running, so later pulses come every P*N cycles in timer mode.
- R5: In counter mode (bit 6 = 1) each qualifying trigger edge decrements the counter once. Bit 4 = 1 selects rising edges and bit 4 = 0 selects falling edges. The zero-count pulse is seen 3 cycles after the trigger transition that completes the count.
- R6: In timer mode with bit 3 = 1, writing the time constant does not start counting. A qualifying trigger edge starts it, and the first pulse is seen 3+P*N cycles after that transition. Trigger edges that arrive while the timer is running have no effect.
- R7: The zero-count pulse is high for exactly one clock cycle.
- R8: With bit 7 set, the interrupt request goes high in the same cycle as the zero-count pulse. It stays high until `irq_clr` is asserted, which clears it. With bit 7 clear, zero counts leave the request low.
- R9: A control byte with bit 1 set stops the channel. No further pulse appears until a new time constant is written.
- R10: After reset, both `zc_pulse` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | DATA_W | Control byte or time-constant byte |
| trig_in | input | 1 | Asynchronous external clock/trigger |
| irq_clr | input | 1 | Clears the interrupt request |
| zc_pulse | output | 1 | One-cycle zero-count pulse |
| irq | output | 1 | Sticky interrupt request |

## Verification
Results arrive at fixed latencies:

- In timer mode with automatic start, the first pulse is due P*N cycles after the edge that takes the time-constant write. Later pulses follow every P*N cycles.
- A trigger transition reaches the counter 3 cycles later: two synchronizer flops, then the edge that decrements or starts. So counter-mode pulses are due 3 cycles after the transition, and a triggered timer's first pulse is due 3+P*N cycles after it.
- The interrupt request rises in the same cycle as the pulse.

The bench keeps a free-running cycle number and samples on falling edges. It compares the cycle number of each observed pulse against these sums exactly, and it counts pulses over fixed windows for the cases where nothing may happen.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  // Control byte bit positions
  localparam int unsigned CW_IRQ    = 7;
  localparam int unsigned CW_CNT    = 6;
  localparam int unsigned CW_PRE    = 5;
  localparam int unsigned CW_RISE   = 4;
  localparam int unsigned CW_TSTART = 3;
  localparam int unsigned CW_TCNEXT = 2;
  localparam int unsigned CW_SRST   = 1;

  typedef struct packed {
    logic irq_en;
    logic cnt_mode;
    logic pre_hi;
    logic rise;
    logic trig_start;
  } chan_cfg_t;

  function automatic chan_cfg_t decode_ctrl(input logic [7:0] b);
    chan_cfg_t c;
    c.irq_en     = b[CW_IRQ];
    c.cnt_mode   = b[CW_CNT];
    c.pre_hi     = b[CW_PRE];
    c.rise       = b[CW_RISE];
    c.trig_start = b[CW_TSTART];
    return c;
  endfunction

endpackage

// File: rtl/ctc_trig_sync.sv
module ctc_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  input  logic rise_sel,
  output logic edge_ev
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain[0] <= trig_in;
      prev     <= chain[LAST];
    end
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign edge_ev = rise_sel ? (chain[LAST] & ~prev) : (~chain[LAST] & prev);

  // R5
  sync_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (chain[LAST] != prev) |=> (prev == $past(chain[LAST])));

endmodule

// File: rtl/ctc_prescaler.sv
module ctc_prescaler #(
  parameter int unsigned DIV_LO = 16,
  parameter int unsigned DIV_HI = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic sel_hi,
  output logic tick
);
  localparam int unsigned W = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;
  localparam logic [W-1:0] LIM_LO = W'(DIV_LO - 1);
  localparam logic [W-1:0] LIM_HI = W'(DIV_HI - 1);

  logic [W-1:0] cnt;
  logic [W-1:0] lim;

  assign lim  = sel_hi ? LIM_HI : LIM_LO;
  assign tick = run & (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (run) begin
      if (cnt >= lim) cnt <= '0;
      else            cnt <= cnt + 1'b1;
    end
  end

  // R3
  presc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !clr && !tick) |=> (cnt == $past(cnt) + 1'b1));

  // R3
  presc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr) |=> (cnt == '0));

endmodule

// File: rtl/ctc_downcount.sv
module ctc_downcount #(
  parameter int unsigned TC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [TC_W-1:0] tc,
  input  logic            dec,
  output logic            term
);
  localparam int unsigned CW = TC_W + 1;
  localparam logic [CW-1:0] FULL = CW'(1) << TC_W;

  logic [CW-1:0] cnt;
  logic [CW-1:0] reload;
  logic [CW-1:0] load_val;

  assign load_val = (tc == '0) ? FULL : {1'b0, tc};
  assign term     = dec & ~load & (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      reload <= '0;
    end else if (load) begin
      cnt    <= load_val;
      reload <= load_val;
    end else if (dec) begin
      if (cnt == CW'(1)) cnt <= reload;
      else               cnt <= cnt - 1'b1;
    end
  end

  // R2
  cnt_live_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |-> (cnt != '0));

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    term |=> (cnt == $past(reload)));

endmodule

// File: rtl/ctr_timer_chan.sv
module ctr_timer_chan #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PRE_LO      = 16,
  parameter int unsigned PRE_HI      = 256,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              trig_in,
  input  logic              irq_clr,
  output logic              zc_pulse,
  output logic              irq
);
  import ctc_pkg::*;

  localparam int unsigned TC_W = DATA_W;

  chan_cfg_t cfg;
  logic      tc_next;
  logic      running;
  logic      armed;
  logic      edge_ev;
  logic      tick;
  logic      term;
  logic      tc_wr;
  logic      ctl_wr;
  logic      srst_wr;
  logic      start_ev;
  logic      presc_clr;
  logic      presc_run;
  logic      dec;

  assign tc_wr     = wr_en & tc_next;
  assign ctl_wr    = wr_en & ~tc_next;
  assign srst_wr   = ctl_wr & wr_data[CW_SRST];
  assign start_ev  = armed & edge_ev & ~cfg.cnt_mode & ~wr_en;
  assign presc_clr = tc_wr | start_ev;
  assign presc_run = running & ~cfg.cnt_mode;
  assign dec       = running & ~tc_wr & (cfg.cnt_mode ? edge_ev : tick);

  ctc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .trig_in (trig_in),
    .rise_sel(cfg.rise),
    .edge_ev (edge_ev)
  );

  ctc_prescaler #(.DIV_LO(PRE_LO), .DIV_HI(PRE_HI)) u_presc (
    .clk   (clk),
    .rst   (rst),
    .clr   (presc_clr),
    .run   (presc_run),
    .sel_hi(cfg.pre_hi),
    .tick  (tick)
  );

  ctc_downcount #(.TC_W(TC_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .load(tc_wr),
    .tc  (wr_data[TC_W-1:0]),
    .dec (dec),
    .term(term)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      tc_next  <= 1'b0;
      running  <= 1'b0;
      armed    <= 1'b0;
      zc_pulse <= 1'b0;
      irq      <= 1'b0;
    end else begin
      zc_pulse <= term;
      if (term && cfg.irq_en) irq <= 1'b1;
      else if (irq_clr)       irq <= 1'b0;

      if (tc_wr) begin
        tc_next <= 1'b0;
        if (cfg.cnt_mode || !cfg.trig_start) begin
          running <= 1'b1;
          armed   <= 1'b0;
        end else begin
          running <= 1'b0;
          armed   <= 1'b1;
        end
      end else if (ctl_wr) begin
        cfg     <= decode_ctrl(wr_data[7:0]);
        tc_next <= wr_data[CW_TCNEXT];
        if (wr_data[CW_SRST]) begin
          running <= 1'b0;
          armed   <= 1'b0;
        end
      end else if (start_ev) begin
        running <= 1'b1;
        armed   <= 1'b0;
      end
    end
  end

  // R7
  zc_width_chk: assert property (@(posedge clk) disable iff (rst)
    zc_pulse |=> !zc_pulse);

  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (term && cfg.irq_en) |=> (irq && zc_pulse));

  // R8
  irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !term) |=> !irq);

  // R9
  srst_stop_chk: assert property (@(posedge clk) disable iff (rst)
    srst_wr |=> ##1 !zc_pulse);

endmodule

// File: tb/sim_ctr_timer_chan.sv
module sim_ctr_timer_chan;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       trig_in = 1'b0;
  logic       irq_clr = 1'b0;
  logic       zc_pulse;
  logic       irq;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  ctr_timer_chan u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .trig_in(trig_in), .irq_clr(irq_clr), .zc_pulse(zc_pulse), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_interval(input bit p256, input int tcb);
    int p = p256 ? 256 : 16;
    int n = (tcb == 0) ? 256 : tcb;
    return p * n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b, output int at);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
    at = cyc;
  endtask

  task automatic prog(input logic [7:0] ctl, input logic [7:0] tc, output int at);
    int d;
    wr(ctl, d);
    wr(tc, at);
  endtask

  task automatic wait_zc(input int maxc, output int at);
    int i = 0;
    at = -1;
    while (i < maxc && at < 0) begin
      @(negedge clk);
      if (zc_pulse) at = cyc;
      i++;
    end
  endtask

  task automatic count_zc(input int ncyc, output int cnt);
    cnt = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (zc_pulse) cnt++;
    end
  endtask

  task automatic trig_pulses(input int n, input int hi, input int lo,
                             output int cnt, output int first_zc,
                             output int first_rise, output int last_rise,
                             output int last_fall);
    cnt = 0; first_zc = -1; first_rise = -1; last_rise = -1; last_fall = -1;
    for (int k = 0; k < n; k++) begin
      for (int h = 0; h < hi; h++) begin
        @(negedge clk);
        if (zc_pulse) begin cnt++; if (first_zc < 0) first_zc = cyc; end
        if (h == 0) begin
          trig_in = 1'b1;
          last_rise = cyc;
          if (first_rise < 0) first_rise = cyc;
        end
      end
      for (int l = 0; l < lo; l++) begin
        @(negedge clk);
        if (zc_pulse) begin cnt++; if (first_zc < 0) first_zc = cyc; end
        if (l == 0) begin trig_in = 1'b0; last_fall = cyc; end
      end
    end
    for (int t = 0; t < 5; t++) begin
      @(negedge clk);
      if (zc_pulse) begin cnt++; if (first_zc < 0) first_zc = cyc; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int w, a, b, c, cnt, fz, fr, lr, lf;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(zc_pulse == 1'b0 && irq == 1'b0, "R10", {zc_pulse, irq}, 0);
    count_zc(40, cnt);
    check(cnt == 0, "R10 idle", cnt, 0);

    // R3 / R1: timer P=16, time constant 0x03 (bit1 set but taken as constant)
    prog(8'h04, 8'h03, w);
    wait_zc(200, a);
    check(a == w + exp_interval(0, 3), "R3 first pulse", a - w, exp_interval(0, 3));
    @(negedge clk);
    // R7
    check(zc_pulse == 1'b0, "R7 width", zc_pulse, 0);
    wait_zc(200, b);
    // R4
    check(b - a == 48, "R4 reload interval", b - a, 48);

    // R3 / R4: P=256, N=2
    prog(8'h24, 8'h02, w);
    wait_zc(1200, a);
    check(a - w == exp_interval(1, 2), "R3 P256", a - w, exp_interval(1, 2));
    wait_zc(1200, b);
    check(b - a == 512, "R4 P256 reload", b - a, 512);

    // R2: 0x00 means 256
    prog(8'h04, 8'h00, w);
    wait_zc(5000, a);
    check(a - w == 4096, "R2 zero constant", a - w, 4096);

    // R8: interrupts enabled
    prog(8'h84, 8'h01, w);
    @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    wait_zc(40, a);
    check(irq == 1'b1, "R8 irq with pulse", irq, 1);
    count_zc(3, cnt);
    check(irq == 1'b1, "R8 irq held", irq, 1);
    @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    check(irq == 1'b0, "R8 irq cleared", irq, 0);
    // R8 disabled
    prog(8'h04, 8'h01, w);
    count_zc(40, cnt);
    check(cnt >= 2 && irq == 1'b0, "R8 irq disabled", irq, 0);

    // R1 / R9: control 0x00 keeps running, then 0x02 is a soft reset
    prog(8'h04, 8'h01, w);
    wr(8'h00, w);
    count_zc(40, cnt);
    check(cnt >= 2, "R1 control keeps running", cnt, 2);
    wr(8'h02, w);
    count_zc(100, cnt);
    check(cnt == 0, "R9 soft reset stops", cnt, 0);
    prog(8'h04, 8'h01, w);
    wait_zc(40, a);
    check(a - w == 16, "R9 restart", a - w, 16);

    // R5 counter rising, N=4
    prog(8'h54, 8'h04, w);
    trig_pulses(4, 3, 3, cnt, fz, fr, lr, lf);
    check(cnt == 1, "R5 rising count", cnt, 1);
    check(fz == lr + 3, "R5 rising latency", fz - lr, 3);
    // R5 counter falling, N=2
    prog(8'h44, 8'h02, w);
    trig_pulses(2, 3, 4, cnt, fz, fr, lr, lf);
    check(cnt == 1, "R5 falling count", cnt, 1);
    check(fz == lf + 3, "R5 falling latency", fz - lf, 3);

    // R6 trigger-started timer P=16 N=2
    prog(8'h1C, 8'h02, w);
    count_zc(100, cnt);
    check(cnt == 0, "R6 waits for trigger", cnt, 0);
    trig_pulses(4, 5, 5, cnt, fz, fr, lr, lf);
    check(fz == fr + 3 + 32, "R6 start latency", fz - fr, 35);
    check(cnt == 1, "R6 extra edges ignored", cnt, 1);
    wait_zc(100, c);
    check(c - fz == 32, "R6 interval unchanged", c - fz, 32);

    // Random timer runs (R3 R4)
    for (int i = 0; i < 6; i++) begin
      bit p = 1'($urandom % 2);
      int n = 1 + int'($urandom % 8);
      int e = exp_interval(p, n);
      prog(p ? 8'h24 : 8'h04, 8'(n), w);
      wait_zc(e + 20, a);
      check(a - w == e, "R3 random first", a - w, e);
      wait_zc(e + 20, b);
      check(b - a == e, "R4 random reload", b - a, e);
    end

    // Random counter runs (R5)
    for (int i = 0; i < 6; i++) begin
      int n = 4 + int'($urandom % 12);
      int t = 1 + int'($urandom % 5);
      prog(8'h54, 8'(t), w);
      trig_pulses(n, 2 + int'($urandom % 3), 2 + int'($urandom % 3), cnt, fz, fr, lr, lf);
      check(cnt == n / t, "R5 random count", cnt, n / t);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule